// File: doc/BRIEF.md
# Asymmetric Line Noise Canceller

This block turns one asynchronous, open-drain style serial bus line into a clean logic level that downstream bit-timing logic can trust. The raw line is first brought into the clock domain through a short flop chain. After that it is looked at only when a sample-enable pulse is high. A sample is one clock cycle with the enable asserted.

The filtered level moves to the opposite value only after a programmed number of back-to-back samples at that new value. Any shorter excursion is dropped as noise. The count needed to go low and the count needed to go high are programmed separately. Each comes from a small encoded field, and a field value of v asks for v+1 samples. A one-cycle strobe marks each accepted rising change and each accepted falling change.

Top module: `line_noise_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `line_o` is 1 and both `rise_o` and `fall_o` are 0.
- R2: The raw input passes through two synchroniser flops before it is sampled. With both threshold fields at 0 and `sample_en_i` held high, a raw change is reflected on `line_o` after the third rising clock edge, and not after the second.
- R3: In a cycle where `sample_en_i` is 0, the filtered level and the run count do not change, whatever the raw line does.
- R4: A change of `line_o` from 1 to 0 happens only after `fall_thr_i`+1 consecutive samples of 0. The field is 3 bits wide, and 3'b011 asks for 4 samples.
- R5: A change of `line_o` from 0 to 1 happens only after `rise_thr_i`+1 consecutive samples of 1. The field is 2 bits wide, and 2'b10 asks for 3 samples.
- R6: A run of differing samples that ends, before it reaches the count, with a sample equal to `line_o` is discarded. `line_o` keeps its level, and the next excursion must build its full run again.
- R7: After a change is accepted, the run count starts from zero, so a return to the previous level needs its own full run of samples.
- R8: `rise_o` is high for exactly the one cycle in which `line_o` has just gone from 0 to 1. `fall_o` is high for exactly the one cycle in which `line_o` has just gone from 1 to 0. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_raw_i | input | 1 | Raw asynchronous bus line |
| sample_en_i | input | 1 | Sample strobe, one clock wide per sample |
| rise_thr_i | input | 2 | Rise confirmation field, samples = value+1 |
| fall_thr_i | input | 3 | Fall confirmation field, samples = value+1 |
| line_o | output | 1 | Filtered line level |
| rise_o | output | 1 | One-cycle strobe on an accepted 0-to-1 change |
| fall_o | output | 1 | One-cycle strobe on an accepted 1-to-0 change |

## Verification
The assertions take for granted that `sample_en_i` and both threshold fields are synchronous to `clk`. Only `line_raw_i` may change freely. A threshold field may change in the middle of a run. Each run check therefore compares against the field value present at the accepting sample, not a value latched earlier. The stimulus follows these rules: it drives every input away from the active edge, and it reloads the thresholds at random moments, including during runs. The raw line is driven as runs of random length from one cycle upward, so the glitches come out both shorter and longer than the programmed counts.

// File: rtl/lnf_pkg.sv
package lnf_pkg;

   typedef enum logic [1:0] {
      EV_NONE = 2'b00,
      EV_RISE = 2'b01,
      EV_FALL = 2'b10
   } lnf_event_e;

   function automatic int unsigned lnf_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lnf_sync.sv
module lnf_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lnf_sync: STAGES must be at least 2");
      end

      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[i] <= RESET_VAL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lnf_thresh_decode.sv
module lnf_thresh_decode #(
   parameter int unsigned FIELD_W = 2,
   parameter int unsigned CNT_W   = 4
) (
   input  logic [FIELD_W-1:0] field_i,
   output logic [CNT_W:0]     need_o
);

   localparam int unsigned PAD_W = CNT_W + 1 - FIELD_W;

   generate
      if (CNT_W < FIELD_W) begin : g_bad_width
         $error("lnf_thresh_decode: CNT_W narrower than FIELD_W");
      end
   endgenerate

   // A field value v asks for v+1 consecutive samples.
   assign need_o = {{PAD_W{1'b0}}, field_i} + {{CNT_W{1'b0}}, 1'b1};

endmodule

// File: rtl/lnf_run_counter.sv
module lnf_run_counter #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (inc_i)   cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/line_noise_filter.sv
module line_noise_filter
   import lnf_pkg::*;
#(
   parameter int unsigned HI_W        = 2,
   parameter int unsigned LO_W        = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        IDLE_LEVEL  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            line_raw_i,
   input  logic            sample_en_i,
   input  logic [HI_W-1:0] rise_thr_i,
   input  logic [LO_W-1:0] fall_thr_i,
   output logic            line_o,
   output logic            rise_o,
   output logic            fall_o
);

   localparam int unsigned CNT_W = lnf_max(HI_W, LO_W) + 1;

   generate
      if (HI_W < 1 || LO_W < 1) begin : g_bad_fields
         $error("line_noise_filter: threshold fields need at least one bit");
      end
   endgenerate

   logic             sync_q;
   logic [CNT_W:0]   need_hi;
   logic [CNT_W:0]   need_lo;
   logic [CNT_W:0]   need_sel;
   logic [CNT_W-1:0] run_cnt;
   logic             level_q;
   lnf_event_e       ev_q;
   logic             differ;
   logic             reached;
   logic             accept;
   logic             cnt_clear;
   logic             cnt_inc;

   lnf_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (IDLE_LEVEL)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_raw_i),
      .q_o   (sync_q)
   );

   lnf_thresh_decode #(
      .FIELD_W (HI_W),
      .CNT_W   (CNT_W)
   ) u_dec_hi (
      .field_i (rise_thr_i),
      .need_o  (need_hi)
   );

   lnf_thresh_decode #(
      .FIELD_W (LO_W),
      .CNT_W   (CNT_W)
   ) u_dec_lo (
      .field_i (fall_thr_i),
      .need_o  (need_lo)
   );

   always_comb begin
      differ    = sync_q ^ level_q;
      need_sel  = sync_q ? need_hi : need_lo;
      reached   = ({1'b0, run_cnt} + {{CNT_W{1'b0}}, 1'b1}) >= need_sel;
      accept    = sample_en_i && differ && reached;
      cnt_clear = sample_en_i && (!differ || accept);
      cnt_inc   = sample_en_i && differ && !reached;
   end

   lnf_run_counter #(
      .CNT_W (CNT_W)
   ) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (cnt_clear),
      .inc_i   (cnt_inc),
      .cnt_o   (run_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= IDLE_LEVEL;
         ev_q    <= EV_NONE;
      end else begin
         if (accept) begin
            level_q <= sync_q;
            ev_q    <= sync_q ? EV_RISE : EV_FALL;
         end else begin
            ev_q    <= EV_NONE;
         end
      end
   end

   assign line_o = level_q;
   assign rise_o = (ev_q == EV_RISE);
   assign fall_o = (ev_q == EV_FALL);

endmodule

// File: rtl/lnf_checker.sv
module lnf_checker #(
   parameter int unsigned HI_W = 2,
   parameter int unsigned LO_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            samp,
   input logic            sample_en_i,
   input logic [HI_W-1:0] rise_thr_i,
   input logic [LO_W-1:0] fall_thr_i,
   input logic            line_o,
   input logic            rise_o,
   input logic            fall_o
);

   localparam int unsigned RW = 5;

   logic [RW-1:0] run_q;
   logic [RW-1:0] run_base;
   logic          line_d;
   logic [RW-1:0] need_m1;

   // The stored run is stale in the cycle after the level moved.
   assign run_base = (line_o != line_d) ? '0 : run_q;
   assign need_m1  = samp ? RW'(rise_thr_i) : RW'(fall_thr_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         line_d <= 1'b1;
      end else begin
         line_d <= line_o;
         if (sample_en_i) begin
            if (samp != line_o) run_q <= run_base + 1'b1;
            else                run_q <= '0;
         end else begin
            run_q <= run_base;
         end
      end
   end

   // R3: no sample, no movement
   a_r3_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en_i |=> $stable(line_o));

   // R8: strobes exclusive
   a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise_o, fall_o}));

   // R8: rise strobe marks a 0-to-1 change
   a_r8_rise_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> (line_o && !line_d));

   // R8: fall strobe marks a 1-to-0 change
   a_r8_fall_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> (!line_o && line_d));

   // R8: every level change is strobed
   a_r8_change_strobed: assert property (@(posedge clk) disable iff (!rst_n)
      (line_o != line_d) |-> (rise_o || fall_o));

   // R4: falling needs fall_thr+1 samples
   a_r4_fall_run: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en_i && line_o && !samp) |=> (line_o || ($past(run_base) >= RW'($past(fall_thr_i)))));

   // R5: rising needs rise_thr+1 samples
   a_r5_rise_run: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en_i && !line_o && samp) |=> (!line_o || ($past(run_base) >= RW'($past(rise_thr_i)))));

   // R6: a matching sample keeps the level
   a_r6_match_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en_i && (samp == line_o)) |=> $stable(line_o));

   // R4, R5: a completed run is always accepted
   a_r5_no_missed_change: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en_i && (samp != line_o) && (run_base >= need_m1)) |=> (line_o == $past(samp)));

endmodule

bind line_noise_filter lnf_checker #(
   .HI_W (HI_W),
   .LO_W (LO_W)
) u_lnf_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .samp        (sync_q),
   .sample_en_i (sample_en_i),
   .rise_thr_i  (rise_thr_i),
   .fall_thr_i  (fall_thr_i),
   .line_o      (line_o),
   .rise_o      (rise_o),
   .fall_o      (fall_o)
);

// File: tb/line_noise_filter_test.sv
module line_noise_filter_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       line_raw_i;
   logic       sample_en_i;
   logic [1:0] rise_thr_i;
   logic [2:0] fall_thr_i;
   logic       line_o;
   logic       rise_o;
   logic       fall_o;

   int checks = 0;
   int errors = 0;

   // bench model state
   logic m_s1, m_s2, m_lvl, m_rise, m_fall;
   int   m_run;

   always #2 clk = ~clk;

   line_noise_filter uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_raw_i  (line_raw_i),
      .sample_en_i (sample_en_i),
      .rise_thr_i  (rise_thr_i),
      .fall_thr_i  (fall_thr_i),
      .line_o      (line_o),
      .rise_o      (rise_o),
      .fall_o      (fall_o)
   );

   function automatic int need_of(input logic s, input logic [1:0] hi, input logic [2:0] lo);
      return s ? (int'(hi) + 1) : (int'(lo) + 1);
   endfunction

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {line,rise,fall} actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // one model step for an edge that saw the given inputs
   task automatic model_edge(input logic raw, input logic en, input logic rst);
      logic s;
      s = m_s2;
      m_rise = 1'b0;
      m_fall = 1'b0;
      if (!rst) begin
         m_s1 = 1'b1; m_s2 = 1'b1; m_lvl = 1'b1; m_run = 0;
      end else begin
         if (en) begin
            if (s == m_lvl) m_run = 0;
            else if (m_run + 1 >= need_of(s, rise_thr_i, fall_thr_i)) begin
               m_lvl = s; m_run = 0;
               if (s) m_rise = 1'b1; else m_fall = 1'b1;
            end else m_run++;
         end
         m_s2 = m_s1;
         m_s1 = raw;
      end
   endtask

   // drive, clock, model, compare; inputs held across one posedge
   task automatic step(input logic raw, input logic en, input string req);
      string tag;
      line_raw_i  = raw;
      sample_en_i = en;
      @(posedge clk);
      @(negedge clk);
      model_edge(raw, en, rst_n);
      tag = req;
      if (tag == "") tag = m_fall ? "R4" : (m_rise ? "R5" : "R6");
      check(tag, {line_o, rise_o, fall_o}, {m_lvl, m_rise, m_fall});
   endtask

   task automatic run_level(input logic raw, input int n, input string req);
      for (int i = 0; i < n; i++) step(raw, 1'b1, req);
   endtask

   task automatic settle_high;
      rise_thr_i = 2'd0;
      run_level(1'b1, 4, "R6");
   endtask

   logic done = 1'b0;

   initial begin
      #800000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      int len;
      logic lv;
      seed = 32'h1bad5eed;
      void'($urandom(seed));
      rst_n = 1'b0; line_raw_i = 1'b1; sample_en_i = 1'b0;
      rise_thr_i = 2'd0; fall_thr_i = 3'd0;
      m_s1 = 1'b1; m_s2 = 1'b1; m_lvl = 1'b1; m_run = 0; m_rise = 1'b0; m_fall = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R1");
      check("R1", {line_o, rise_o, fall_o}, 3'b100);
      rst_n = 1'b1;
      step(1'b1, 1'b0, "R1");
      check("R1", {line_o, rise_o, fall_o}, 3'b100);

      // R2: latency through two synchroniser flops
      rise_thr_i = 2'd0; fall_thr_i = 3'd0;
      run_level(1'b1, 3, "R2");
      step(1'b0, 1'b1, "R2");
      step(1'b0, 1'b1, "R2");
      check("R2", {line_o, rise_o, fall_o}, 3'b100);
      step(1'b0, 1'b1, "R2");
      check("R2", {line_o, rise_o, fall_o}, 3'b001);
      step(1'b0, 1'b1, "R8");
      check("R8", {line_o, rise_o, fall_o}, 3'b000);
      run_level(1'b1, 3, "R5");
      check("R8", {line_o, rise_o, fall_o}, 3'b110);

      // R3: samples ignored while enable is low
      settle_high();
      fall_thr_i = 3'd0;
      for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "R3");
      check("R3", {line_o, rise_o, fall_o}, 3'b100);
      step(1'b1, 1'b0, "R3");
      step(1'b1, 1'b0, "R3");
      step(1'b1, 1'b1, "R3");
      check("R3", {line_o, rise_o, fall_o}, 3'b100);

      // R4: field 3'b011 needs four zero samples
      settle_high();
      fall_thr_i = 3'd3;
      run_level(1'b0, 5, "R4");
      check("R4", {line_o, rise_o, fall_o}, 3'b100);
      step(1'b0, 1'b1, "R4");
      check("R4", {line_o, rise_o, fall_o}, 3'b001);

      // R7 and R5: field 2'b10 needs three one samples right after the fall
      rise_thr_i = 2'd2;
      run_level(1'b1, 4, "R7");
      check("R7", {line_o, rise_o, fall_o}, 3'b000);
      step(1'b1, 1'b1, "R5");
      check("R5", {line_o, rise_o, fall_o}, 3'b110);

      // R6: three zeros then a one is discarded, then another short run
      settle_high();
      fall_thr_i = 3'd3;
      run_level(1'b0, 3, "R6");
      run_level(1'b1, 1, "R6");
      run_level(1'b0, 3, "R6");
      run_level(1'b1, 4, "R6");
      check("R6", {line_o, rise_o, fall_o}, 3'b100);

      // R4 with the widest field: eight samples
      fall_thr_i = 3'd7;
      run_level(1'b0, 9, "R4");
      check("R4", {line_o, rise_o, fall_o}, 3'b100);
      step(1'b0, 1'b1, "R4");
      check("R4", {line_o, rise_o, fall_o}, 3'b001);

      // random mix checked against the model
      lv = 1'b1;
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 7) == 0) begin
            rise_thr_i = 2'($urandom_range(0, 3));
            fall_thr_i = 3'($urandom_range(0, 7));
         end
         lv  = ~lv;
         len = $urandom_range(1, 10);
         for (int k = 0; k < len; k++)
            step(lv, ($urandom_range(0, 3) != 0), "");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule